// File: doc/BRIEF.md
# Edge-Triggered Digital Monostable

This block turns each rising edge of a slow external rate signal, such as a PWM line from a microcontroller, into one output pulse whose length is a set number of clock cycles. The trigger input is asynchronous to the clock. A two-stage synchroniser brings it into the clock domain, and a rising-edge detector then reduces each low-to-high change to a strobe one clock wide.

A two-state machine drives the output. `IDLE` waits for a strobe. The transition `START` (strobe seen, width nonzero) moves it to `RUN` and, in the same cycle, loads a width counter from the parallel width input. The transition `REJECT` (strobe seen, width zero) keeps it in `IDLE`. The transition `HOLD` keeps it in `RUN` while the counter counts down, once per cycle. The transition `DONE`, taken when the counter reaches its last count, returns it to `IDLE`. The counter saturates at zero, and everything stays paused until the next trigger edge. Any strobe that arrives while the state is `RUN` is dropped. The output is high exactly while the state is `RUN`.

Top module: `edge_oneshot`

## Requirements
- R1: After reset, `pulse_out` is low and no pulse starts until a trigger rising edge is seen.
- R2: If `trig_in` is first sampled high at clock edge k, `pulse_out` goes high after clock edge k+2. This covers two synchroniser stages and the state register, with the strobe produced by combinational logic from the synchroniser.
- R3: Each low-to-high change of `trig_in` yields exactly one strobe. Holding `trig_in` high produces only one pulse.
- R4: For a width value W from 1 up to the maximum, `pulse_out` stays high for exactly W consecutive clock cycles.
- R5: The width value is captured only on the strobe cycle. Changing `width_val` while a pulse is in progress does not change that pulse's length.
- R6: A trigger edge whose strobe arrives while the state is `RUN` is ignored. It neither lengthens the pulse nor starts a second one.
- R7: A width value of zero produces no output pulse.
- R8: After a pulse ends, the counter rests at zero and the block stays idle. A falling edge of `trig_in` produces no pulse.
- R9: The largest width, 2^CW-1, gives a pulse of exactly that length with no wrap of the counter.
- R10: A strobe that arrives on the first idle cycle after a pulse ends starts a new pulse at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous trigger; its rising edge starts a pulse |
| width_val | input | CW | Pulse length in clock cycles, captured on the strobe |
| pulse_out | output | 1 | One-shot output, high while a pulse is in progress |

## Verification
The bench targets the off-by-one boundaries of the width counter.

- **Width extremes.** It drives widths of 1 and the maximum. A terminal count taken at zero instead of one would give one extra cycle, and a counter that wrapped would run far past the maximum.
- **Retrigger during a pulse.** It retriggers in the middle of a pulse. A design that reloaded on every strobe would show a stretched pulse.
- **Width change during a pulse.** It changes the width value in the middle of a pulse. A design that read the width continuously would cut the pulse short.
- **Retrigger on the first idle cycle.** It places a second edge so that its strobe lands on the first idle cycle. A design that returned to idle one cycle late would drop that pulse.
- **Zero width and falling edge.** It applies a zero width and a falling edge of the trigger. A design that treated zero as the maximum, or detected both edges, would emit a spurious pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_RUN  = 1'b1
    } os_state_t;

endpackage

// File: rtl/trig_sync_edge.sv
// Multi-stage synchroniser followed by a rising-edge detector.
module trig_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_strobe
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_strobe = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/width_counter.sv
// Loadable down-counter that saturates at zero and only moves when enabled.
module width_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run_en,
    output logic [CW-1:0] count,
    output logic          at_last
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] ZERO = '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= ZERO;
        end else if (load) begin
            count <= load_val;
        end else if (run_en && count != ZERO) begin
            count <= count - ONE;
        end
    end

    assign at_last = (count == ONE);
endmodule

// File: rtl/oneshot_fsm.sv
// Two-state control: IDLE waits for a strobe, RUN holds until the last count.
module oneshot_fsm
    import oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic width_zero,
    input  logic at_last,
    output logic load_cnt,
    output logic run
);
    os_state_t state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE: if (strobe && !width_zero) state_d = OS_RUN;   // START
                     // REJECT: strobe with zero width stays idle
            OS_RUN:  if (at_last) state_d = OS_IDLE;                // DONE, else HOLD
            default: state_d = OS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OS_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        load_cnt = 1'b0;
        run      = 1'b0;
        unique case (state_q)
            OS_IDLE: load_cnt = strobe;
            OS_RUN:  run      = 1'b1;
            default: run      = 1'b0;
        endcase
    end
endmodule

// File: rtl/edge_oneshot.sv
module edge_oneshot #(
    parameter int CW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_in,
    input  logic [CW-1:0] width_val,
    output logic          pulse_out
);
    logic          edge_strobe;
    logic          load_cnt;
    logic          run;
    logic          at_last;
    logic [CW-1:0] count_q;

    trig_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .async_in    (trig_in),
        .rise_strobe (edge_strobe)
    );

    oneshot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (edge_strobe),
        .width_zero (width_val == '0),
        .at_last    (at_last),
        .load_cnt   (load_cnt),
        .run        (run)
    );

    width_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_cnt),
        .load_val (width_val),
        .run_en   (run),
        .count    (count_q),
        .at_last  (at_last)
    );

    assign pulse_out = run;
endmodule

// File: rtl/edge_oneshot_chk.sv
module edge_oneshot_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strobe,
    input logic          pulse_out,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] width_val
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // R2
    rise_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(strobe));

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R4
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && cnt > ONE) |=> (pulse_out && cnt == CW'($past(cnt) - ONE)));

    // R4
    last_count_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && cnt == ONE) |=> !pulse_out);

    // R5
    width_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !pulse_out) |=> (cnt == $past(width_val)));

    // R6
    retrigger_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && strobe && cnt > ONE) |=> (pulse_out && cnt == CW'($past(cnt) - ONE)));

    // R7
    zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !pulse_out && width_val == '0) |=> !pulse_out);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_out && !strobe) |=> (!pulse_out && $stable(cnt)));

    // R9
    saturate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_out) |-> (cnt == '0));
endmodule

bind edge_oneshot edge_oneshot_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (edge_strobe),
    .pulse_out (pulse_out),
    .cnt       (count_q),
    .width_val (width_val)
);

// File: tb/edge_oneshot_test.sv
module edge_oneshot_test;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_in = 1'b0;
    logic [CW-1:0] width_val = '0;
    logic          pulse_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    edge_oneshot #(.CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .width_val(width_val), .pulse_out(pulse_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Samples pulse_out at each of the next n falling edges.
    task automatic watch(input int n, output int first, output int highs, output int rises);
        bit prev = 0;
        first = -1; highs = 0; rises = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (pulse_out) begin
                highs++;
                if (!prev) begin
                    rises++;
                    if (first < 0) first = i;
                end
            end
            prev = pulse_out;
        end
    endtask

    task automatic settle();
        @(negedge clk);
        trig_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        int f, h, r;
        watch(6, f, h, r);
        check("R1", "pulses after reset", h, 0);
        check("R1", "pulse_out at reset", int'(pulse_out), 0);
    endtask

    task automatic t_single(input int w, input string req);
        int f, h, r;
        @(negedge clk);
        width_val = CW'(w);
        trig_in = 1'b1;
        watch(w + 12, f, h, r);
        check("R2", "latency", f, 3);
        check(req, "high cycles", h, w);
        check("R3", "pulse count with trigger held", r, 1);
        settle();
    endtask

    task automatic t_retrigger();
        int f, h, r;
        @(negedge clk);
        width_val = CW'(10);
        trig_in = 1'b1;
        fork
            watch(25, f, h, r);
            begin
                repeat (3) @(negedge clk);
                trig_in = 1'b0;
                repeat (3) @(negedge clk);
                trig_in = 1'b1;
            end
        join
        check("R6", "high cycles with mid-pulse edge", h, 10);
        check("R6", "pulse count with mid-pulse edge", r, 1);
        settle();
    endtask

    task automatic t_width_change();
        int f, h, r;
        @(negedge clk);
        width_val = CW'(8);
        trig_in = 1'b1;
        fork
            watch(20, f, h, r);
            begin
                repeat (4) @(negedge clk);
                width_val = CW'(3);
            end
        join
        check("R5", "high cycles after width change", h, 8);
        settle();
    endtask

    task automatic t_zero();
        int f, h, r;
        @(negedge clk);
        width_val = '0;
        trig_in = 1'b1;
        watch(12, f, h, r);
        check("R7", "high cycles for zero width", h, 0);
        settle();
    endtask

    task automatic t_fall();
        int f, h, r;
        @(negedge clk);
        width_val = CW'(5);
        trig_in = 1'b1;
        watch(12, f, h, r);
        trig_in = 1'b0;
        watch(12, f, h, r);
        check("R8", "high cycles after falling edge", h, 0);
        settle();
    endtask

    task automatic t_back_to_back();
        int f, h, r;
        @(negedge clk);
        width_val = CW'(4);
        trig_in = 1'b1;
        fork
            watch(20, f, h, r);
            begin
                repeat (2) @(negedge clk);
                trig_in = 1'b0;
                repeat (3) @(negedge clk);
                trig_in = 1'b1;
            end
        join
        check("R10", "pulse count back to back", r, 2);
        check("R10", "total high cycles back to back", h, 8);
        settle();
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single(1, "R4");
        t_single(5, "R4");
        t_single(17, "R4");
        t_single((1 << CW) - 1, "R9");
        t_retrigger();
        t_width_change();
        t_zero();
        t_fall();
        t_back_to_back();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule